// File: doc/BRIEF.md
# Indirect CSR Select and Alias Access Checker

This block rules on every access to the indirect register window of a processor's control-register file. The window holds one select register per privilege level and a set of alias registers. An alias register reaches whatever register the current select value points at. For each request the checker latches the address, the write flag, the current privilege and virtualization state, the two state-enable gate bits and a stateen-support flag. It then walks the request through a fixed chain of checks and answers with either a grant or an exception code.

The checks run in this order:

1. The stateen gating.
2. The virtualization rules.
3. The presence of a target behind the current select value.
4. The base privilege comparison.

The first check that objects ends the walk. When the hart runs virtualized, an access to a supervisor-level address is steered to the VS-level register. The checker reports this routed level so that the caller can look up the alias target. It also keeps the three select registers itself, which are plain read/write storage.

The checker is an explicit state machine. The states are:

- `ST_IDLE`: ready for a request.
- `ST_STATEEN`: the stateen gating check.
- `ST_VIRT`: the virtualization rules.
- `ST_PROXY`: the alias target check.
- `ST_PRIV`: the base privilege check.
- `ST_DONE`: the one-cycle response.

The transitions are:

- `ST_IDLE` goes to `ST_STATEEN` when a recognised request is accepted.
- `ST_IDLE` goes to `ST_DONE` when an unrecognised address is accepted.
- Each checking state goes to `ST_DONE` when its rule objects.
- Each checking state otherwise advances to the next state in the chain: `ST_STATEEN` to `ST_VIRT` to `ST_PROXY` to `ST_PRIV`.
- `ST_PRIV` always goes to `ST_DONE`.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `icsr_access_checker`

## Requirements
- R1: An address is recognised only when all of the following hold: bits [11:10] are zero, bits [9:8] (the level: 1 = S, 2 = VS, 3 = M) are non-zero, and the low byte is 0x50 (select) or one of 0x51, 0x52, 0x53, 0x55, 0x56, 0x57 (alias). Any other address is refused with illegal-instruction.
- R2: Privilege is encoded 0 = U, 1 = S, 3 = M. The exception code is 0 = none, 1 = illegal, 2 = virtual. A stateen check applies when the level is below M, the privilege is below M and stateen support is on. When it applies and the mstateen0 CSRIND bit is clear, the access is refused with illegal-instruction.
- R3: Under the same conditions as R2, with the mstateen0 bit set, V=1 and the hstateen0 CSRIND bit clear, the access is refused with virtual-instruction.
- R4: Accesses to M-level addresses never take the stateen checks.
- R5: With V=1, an access to a VS-level address raises virtual-instruction. With V=1, a VU-mode (privilege U) access to an S-level address also raises virtual-instruction.
- R6: An alias access whose proxy-present input is low raises illegal-instruction, whatever the value of V. Select-register accesses ignore the proxy-present input.
- R7: The checks are ordered stateen, then virtualization, then proxy presence, then base privilege. Only the first check that fails reports.
- R8: Base privilege requires S for S- and VS-level addresses and M for M-level addresses. The check is skipped when V=1 and the address is S-level, because such an access is remapped to the VS register.
- R9: The select registers reset to zero. A granted write to a select address stores the write data into the select register of the routed level. The routed level is VS when V=1 and the address is S-level, and the address level otherwise. A refused write changes nothing.
- R10: A request is accepted when both `req_valid` and `req_ready` are high. `resp_valid` pulses for one cycle, a number of cycles after acceptance set by the stage that decided: 1 for an address refusal, 2 for stateen, 3 for virtualization, 4 for proxy presence, and 5 for base privilege or grant. `req_ready` is low in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Checker idle, request can be taken |
| req_addr | input | 12 | Register address |
| req_write | input | 1 | Access is a write |
| req_wdata | input | 32 | Write data for select registers |
| req_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| req_virt | input | 1 | Virtualization mode bit V |
| stateen_on | input | 1 | State-enable gating implemented |
| mstateen_ind | input | 1 | Machine stateen0 indirect-access bit |
| hstateen_ind | input | 1 | Hypervisor stateen0 indirect-access bit |
| proxy_present | input | 1 | A register exists behind the current select value |
| resp_valid | output | 1 | Verdict pulse |
| resp_grant | output | 1 | Access may proceed |
| resp_exc | output | 2 | Exception code (0 none, 1 illegal, 2 virtual) |
| resp_level | output | 2 | Routed register level |
| sel_rdata | output | 32 | Select register of the routed level |

## Verification
The main input patterns make two failing rules meet in one request. Stateen faults are combined with VS-level targets, and virtualization faults are combined with a missing proxy. The reported code and the response latency then show which stage ruled first. Further requests hold the address fixed and sweep privilege and V. These separate the remapped S-level case from the base privilege check, and separate the M-level bypass from the stateen gating. Select-register writes are applied at different routed levels, and some are refused on purpose. Reads from every level then tell whether the data reached the right register or, for a refused write, any register at all.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
    localparam int LVL_W  = 2;
    localparam int PRIV_W = 2;

    localparam logic [LVL_W-1:0] LVL_S  = 2'd1;
    localparam logic [LVL_W-1:0] LVL_VS = 2'd2;
    localparam logic [LVL_W-1:0] LVL_M  = 2'd3;

    localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
    localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
    localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_ILLEGAL = 2'd1,
        EXC_VIRTUAL = 2'd2
    } exc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STATEEN,
        ST_VIRT,
        ST_PROXY,
        ST_PRIV,
        ST_DONE
    } chk_state_e;
endpackage

// File: rtl/icsr_addr_decode.sv
module icsr_addr_decode
    import icsr_pkg::*;
#(
    parameter int                     ADDR_W     = 12,
    parameter int                     WIN_BITS   = 3,
    parameter logic [7:0]             WIN_BASE   = 8'h50,
    parameter logic [2**WIN_BITS-1:0] ALIAS_MASK = 8'hEE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              virt,
    output logic              recognised,
    output logic              is_select,
    output logic              is_alias,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  route_level
);
    logic                upper_ok;
    logic                win_hit;
    logic [WIN_BITS-1:0] idx;

    always_comb begin
        upper_ok    = (addr[ADDR_W-1:10] == '0);
        level       = addr[9:8];
        win_hit     = (addr[7:WIN_BITS] == WIN_BASE[7:WIN_BITS]);
        idx         = addr[WIN_BITS-1:0];
        is_select   = upper_ok && (level != '0) && win_hit && (idx == '0);
        is_alias    = upper_ok && (level != '0) && win_hit && (idx != '0) && ALIAS_MASK[idx];
        recognised  = is_select || is_alias;
        route_level = (virt && level == LVL_S) ? LVL_VS : level;
    end
endmodule

// File: rtl/icsr_stage_rules.sv
module icsr_stage_rules
    import icsr_pkg::*;
(
    input  logic [LVL_W-1:0]  level,
    input  logic              is_alias,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              sten,
    input  logic              m_ind,
    input  logic              h_ind,
    input  logic              proxy_ok,
    output exc_e              stateen_exc,
    output exc_e              virt_exc,
    output exc_e              proxy_exc,
    output exc_e              priv_exc
);
    logic [PRIV_W-1:0] need_priv;
    logic              remapped;

    always_comb begin
        stateen_exc = EXC_NONE;
        if (sten && level != LVL_M && priv != PRIV_M) begin
            if (!m_ind)
                stateen_exc = EXC_ILLEGAL;
            else if (virt && !h_ind)
                stateen_exc = EXC_VIRTUAL;
        end

        virt_exc = EXC_NONE;
        if (virt && level != LVL_M) begin
            if (level == LVL_VS)
                virt_exc = EXC_VIRTUAL;
            else if (priv == PRIV_U)
                virt_exc = EXC_VIRTUAL;
        end

        proxy_exc = (is_alias && !proxy_ok) ? EXC_ILLEGAL : EXC_NONE;

        need_priv = (level == LVL_M) ? PRIV_M : PRIV_S;
        remapped  = virt && (level == LVL_S);
        priv_exc  = (!remapped && priv < need_priv) ? EXC_ILLEGAL : EXC_NONE;
    end
endmodule

// File: rtl/icsr_select_bank.sv
module icsr_select_bank
    import icsr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEVELS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  wr_level,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LVL_W-1:0]  rd_level,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_level == LVL_W'(g + 1))
                regs[g] <= wr_data;
        end

        // R9: a select register moves only on a write aimed at its level
        assert_select_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_level == LVL_W'(g + 1)) |=> $stable(regs[g]));
    end

    always_comb begin
        if (rd_level == '0 || int'(rd_level) > LEVELS)
            rd_data = '0;
        else
            rd_data = regs[int'(rd_level) - 1];
    end
endmodule

// File: rtl/icsr_access_checker.sv
module icsr_access_checker
    import icsr_pkg::*;
#(
    parameter int                     ADDR_W     = 12,
    parameter int                     DATA_W     = 32,
    parameter int                     WIN_BITS   = 3,
    parameter logic [7:0]             WIN_BASE   = 8'h50,
    parameter logic [2**WIN_BITS-1:0] ALIAS_MASK = 8'hEE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_priv,
    input  logic              req_virt,
    input  logic              stateen_on,
    input  logic              mstateen_ind,
    input  logic              hstateen_ind,
    input  logic              proxy_present,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic [1:0]        resp_exc,
    output logic [1:0]        resp_level,
    output logic [DATA_W-1:0] sel_rdata
);
    localparam int LEVELS = 3;

    chk_state_e state_q, state_d;
    exc_e       verdict_q, verdict_d;

    logic              dec_rec, dec_sel, dec_alias;
    logic [LVL_W-1:0]  dec_level, dec_route;

    logic [LVL_W-1:0]  level_q, route_q;
    logic              alias_q, select_q, write_q, virt_q;
    logic              sten_q, m_q, h_q, rec_q, proxy_seen_q;
    logic [PRIV_W-1:0] priv_q;
    logic [DATA_W-1:0] wdata_q;

    exc_e stateen_exc, virt_exc, proxy_exc, priv_exc;
    logic accept, wr_en;

    icsr_addr_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_BITS   (WIN_BITS),
        .WIN_BASE   (WIN_BASE),
        .ALIAS_MASK (ALIAS_MASK)
    ) u_decode (
        .addr        (req_addr),
        .virt        (req_virt),
        .recognised  (dec_rec),
        .is_select   (dec_sel),
        .is_alias    (dec_alias),
        .level       (dec_level),
        .route_level (dec_route)
    );

    icsr_stage_rules u_rules (
        .level       (level_q),
        .is_alias    (alias_q),
        .priv        (priv_q),
        .virt        (virt_q),
        .sten        (sten_q),
        .m_ind       (m_q),
        .h_ind       (h_q),
        .proxy_ok    (proxy_present),
        .stateen_exc (stateen_exc),
        .virt_exc    (virt_exc),
        .proxy_exc   (proxy_exc),
        .priv_exc    (priv_exc)
    );

    icsr_select_bank #(
        .DATA_W (DATA_W),
        .LEVELS (LEVELS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_level (route_q),
        .wr_data  (wdata_q),
        .rd_level (route_q),
        .rd_data  (sel_rdata)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign wr_en  = (state_q == ST_PRIV) && (priv_exc == EXC_NONE) && write_q && select_q;

    // next state and verdict
    always_comb begin
        state_d   = state_q;
        verdict_d = verdict_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d   = dec_rec ? ST_STATEEN : ST_DONE;
                    verdict_d = dec_rec ? EXC_NONE : EXC_ILLEGAL;
                end
            end
            ST_STATEEN: begin
                verdict_d = stateen_exc;
                state_d   = (stateen_exc != EXC_NONE) ? ST_DONE : ST_VIRT;
            end
            ST_VIRT: begin
                verdict_d = virt_exc;
                state_d   = (virt_exc != EXC_NONE) ? ST_DONE : ST_PROXY;
            end
            ST_PROXY: begin
                verdict_d = proxy_exc;
                state_d   = (proxy_exc != EXC_NONE) ? ST_DONE : ST_PRIV;
            end
            ST_PRIV: begin
                verdict_d = priv_exc;
                state_d   = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            verdict_q    <= EXC_NONE;
            level_q      <= '0;
            route_q      <= '0;
            alias_q      <= 1'b0;
            select_q     <= 1'b0;
            write_q      <= 1'b0;
            wdata_q      <= '0;
            priv_q       <= '0;
            virt_q       <= 1'b0;
            sten_q       <= 1'b0;
            m_q          <= 1'b0;
            h_q          <= 1'b0;
            rec_q        <= 1'b0;
            proxy_seen_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            verdict_q <= verdict_d;
            if (accept) begin
                level_q      <= dec_level;
                route_q      <= dec_route;
                alias_q      <= dec_alias;
                select_q     <= dec_sel;
                write_q      <= req_write;
                wdata_q      <= req_wdata;
                priv_q       <= req_priv;
                virt_q       <= req_virt;
                sten_q       <= stateen_on;
                m_q          <= mstateen_ind;
                h_q          <= hstateen_ind;
                rec_q        <= dec_rec;
                proxy_seen_q <= 1'b0;
            end else if (state_q == ST_PROXY) begin
                proxy_seen_q <= proxy_present;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_DONE);
        resp_grant = resp_valid && (verdict_q == EXC_NONE);
        resp_exc   = resp_valid ? verdict_q : EXC_NONE;
        resp_level = route_q;
    end

    // R10: an accepted request drops ready on the next cycle
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: the verdict is a one-cycle pulse followed by ready
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R2: a gated stateen bit outranks every later rule
    assert_stateen_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && rec_q && sten_q && level_q != LVL_M && priv_q != PRIV_M && !m_q)
        |-> resp_exc == EXC_ILLEGAL);

    // R5: a VS-level address under V=1 past the stateen gate is virtual
    assert_vs_virtual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && rec_q && virt_q && level_q == LVL_VS && (!sten_q || (m_q && h_q)))
        |-> resp_exc == EXC_VIRTUAL);

    // R6: an alias grant implies a proxy target was seen
    assert_alias_needs_proxy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_grant && alias_q) |-> proxy_seen_q);

    // R9: select data is written only on a granted select write
    assert_write_on_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (resp_grant && sel_rdata == $past(wdata_q)));
endmodule

// File: tb/icsr_access_checker_tb.sv
module icsr_access_checker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_priv = '0;
    logic        req_virt = 1'b0;
    logic        stateen_on = 1'b0;
    logic        mstateen_ind = 1'b0;
    logic        hstateen_ind = 1'b0;
    logic        proxy_present = 1'b0;
    logic        resp_valid;
    logic        resp_grant;
    logic [1:0]  resp_exc;
    logic [1:0]  resp_level;
    logic [31:0] sel_rdata;

    icsr_access_checker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .req_priv      (req_priv),
        .req_virt      (req_virt),
        .stateen_on    (stateen_on),
        .mstateen_ind  (mstateen_ind),
        .hstateen_ind  (hstateen_ind),
        .proxy_present (proxy_present),
        .resp_valid    (resp_valid),
        .resp_grant    (resp_grant),
        .resp_exc      (resp_exc),
        .resp_level    (resp_level),
        .sel_rdata     (sel_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic        grant;
        logic [1:0]  exc;
        int          lat;
        int          t0;
        logic [31:0] sel;
        logic [1:0]  lvl;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] sel_model [4];
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop and compare at each verdict
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R10 unexpected response: actual grant=%0d exc=%0d expected no response",
                         resp_grant, resp_exc);
            end else begin
                bit bad;
                e = sb_q.pop_front();
                n_vec++;
                bad = (resp_grant !== e.grant) || (resp_exc !== e.exc) || ((cyc - e.t0) != e.lat);
                if (e.grant && ((sel_rdata !== e.sel) || (resp_level !== e.lvl)))
                    bad = 1'b1;
                if (bad) begin
                    n_bad++;
                    $display("FAIL %s: actual grant=%0d exc=%0d lat=%0d lvl=%0d sel=%h expected grant=%0d exc=%0d lat=%0d lvl=%0d sel=%h",
                             e.tag, resp_grant, resp_exc, cyc - e.t0, resp_level, sel_rdata,
                             e.grant, e.exc, e.lat, e.lvl, e.sel);
                end
            end
        end
    end

    // reference verdict built from the requirements
    task automatic access(input string tag, input logic [11:0] a, input logic wr,
                          input logic [31:0] wd, input logic [1:0] pv, input logic v,
                          input logic sten, input logic mb, input logic hb, input logic px);
        exp_t       e;
        logic [7:0] lo;
        logic [1:0] lvl;
        bit         is_sel, is_al, rec;
        logic [1:0] need;
        lo     = a[7:0];
        lvl    = a[9:8];
        is_sel = (lo == 8'h50);
        is_al  = (lo == 8'h51 || lo == 8'h52 || lo == 8'h53 ||
                  lo == 8'h55 || lo == 8'h56 || lo == 8'h57);
        rec    = (a[11:10] == 2'b00) && (lvl != 2'd0) && (is_sel || is_al);
        e.tag  = tag;
        e.lvl  = (v && lvl == 2'd1) ? 2'd2 : lvl;
        e.grant = 1'b0;
        e.sel   = '0;
        need    = (lvl == 2'd3) ? 2'd3 : 2'd1;
        if (!rec) begin
            e.exc = 2'd1; e.lat = 1;
        end else if (sten && lvl != 2'd3 && pv != 2'd3 && !mb) begin
            e.exc = 2'd1; e.lat = 2;
        end else if (sten && lvl != 2'd3 && pv != 2'd3 && v && !hb) begin
            e.exc = 2'd2; e.lat = 2;
        end else if (v && lvl != 2'd3 && (lvl == 2'd2 || pv == 2'd0)) begin
            e.exc = 2'd2; e.lat = 3;
        end else if (is_al && !px) begin
            e.exc = 2'd1; e.lat = 4;
        end else if (!(v && lvl == 2'd1) && pv < need) begin
            e.exc = 2'd1; e.lat = 5;
        end else begin
            e.exc = 2'd0; e.lat = 5; e.grant = 1'b1;
            if (wr && is_sel) sel_model[e.lvl] = wd;
            e.sel = sel_model[e.lvl];
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr      = a;
        req_write     = wr;
        req_wdata     = wd;
        req_priv      = pv;
        req_virt      = v;
        stateen_on    = sten;
        mstateen_ind  = mb;
        hstateen_ind  = hb;
        proxy_present = px;
        req_valid     = 1'b1;
        e.t0 = cyc;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) sel_model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (req_ready !== 1'b1 || resp_valid !== 1'b0 || sel_rdata !== 32'h0) begin
            n_bad++;
            $display("FAIL R10 reset state: actual ready=%0d valid=%0d sel=%h expected 1 0 0",
                     req_ready, resp_valid, sel_rdata);
        end

        // R9: reset value read from each level before any write
        access("R9 M select reset zero", 12'h350, 0, 0, 2'd3, 0, 0, 0, 0, 0);
        access("R9 S select reset zero", 12'h150, 0, 0, 2'd3, 0, 0, 0, 0, 0);
        // R9: write S select from M
        access("R9 write S select", 12'h150, 1, 32'hA5A5_0001, 2'd3, 0, 1, 0, 0, 0);
        access("R8 S reads S select", 12'h150, 0, 0, 2'd1, 0, 1, 1, 1, 0);
        // R2 stateen mstateen clear
        access("R2 stateen m clear", 12'h150, 0, 0, 2'd1, 0, 1, 0, 1, 1);
        access("R2 M mode bypasses gate", 12'h150, 0, 0, 2'd3, 0, 1, 0, 0, 1);
        // R3 hstateen clear with V
        access("R3 stateen h clear", 12'h151, 0, 0, 2'd1, 1, 1, 1, 0, 1);
        // R7: stateen illegal outranks VS virtual
        access("R7 stateen before virt", 12'h251, 0, 0, 2'd1, 1, 1, 0, 0, 1);
        // R4 M-level alias skips stateen
        access("R4 M alias from M", 12'h351, 0, 0, 2'd3, 0, 1, 0, 0, 1);
        access("R4 M alias from S reaches priv", 12'h351, 0, 0, 2'd1, 0, 1, 0, 0, 1);
        // R5 virtualization
        access("R5 VS select under V", 12'h250, 0, 0, 2'd1, 1, 0, 0, 0, 1);
        access("R5 VU to S select", 12'h150, 0, 0, 2'd0, 1, 0, 0, 0, 1);
        access("R7 virt before proxy", 12'h256, 0, 0, 2'd1, 1, 1, 1, 1, 0);
        // R6 proxy
        access("R6 missing proxy under V", 12'h151, 0, 0, 2'd1, 1, 1, 1, 1, 0);
        access("R6 missing proxy no V", 12'h153, 0, 0, 2'd1, 0, 0, 0, 0, 0);
        access("R6 select ignores proxy", 12'h150, 0, 0, 2'd1, 0, 0, 0, 0, 0);
        access("R6 alias with proxy", 12'h157, 0, 0, 2'd1, 0, 0, 0, 0, 1);
        access("R7 proxy before priv", 12'h152, 0, 0, 2'd0, 0, 0, 0, 0, 0);
        // R8 base privilege
        access("R8 U to S select", 12'h150, 0, 0, 2'd0, 0, 0, 0, 0, 1);
        access("R8 S to VS select", 12'h250, 0, 0, 2'd1, 0, 0, 0, 0, 1);
        access("R8 U to VS alias", 12'h251, 0, 0, 2'd0, 0, 0, 0, 0, 1);
        access("R8 VS remapped alias", 12'h155, 0, 0, 2'd1, 1, 0, 0, 0, 1);
        // R9 remapped write and isolation
        access("R9 V write routes to VS", 12'h150, 1, 32'h0BAD_F00D, 2'd1, 1, 1, 1, 1, 0);
        access("R9 read VS select", 12'h250, 0, 0, 2'd3, 0, 0, 0, 0, 0);
        access("R9 S select untouched", 12'h150, 0, 0, 2'd3, 0, 0, 0, 0, 0);
        access("R9 refused write", 12'h150, 1, 32'hDEAD_0000, 2'd0, 0, 0, 0, 0, 0);
        access("R9 S select after refusal", 12'h150, 0, 0, 2'd1, 0, 0, 0, 0, 0);
        access("R9 write M select", 12'h350, 1, 32'h1234_5678, 2'd3, 0, 0, 0, 0, 0);
        access("R9 M select readback", 12'h350, 0, 0, 2'd3, 0, 0, 0, 0, 0);
        // R1 decode
        access("R1 hole in window", 12'h154, 0, 0, 2'd3, 0, 0, 0, 0, 1);
        access("R1 upper bits set", 12'h550, 0, 0, 2'd3, 0, 0, 0, 0, 1);
        access("R1 level zero", 12'h050, 0, 0, 2'd3, 0, 0, 0, 0, 1);
        access("R1 outside window", 12'h158, 0, 0, 2'd3, 0, 0, 0, 0, 1);
        access("R10 back to back after refusal", 12'h351, 0, 0, 2'd3, 0, 0, 0, 0, 1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        while (cyc < 20000 && !done) @(negedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R10 watchdog expired: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule